// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral master that sits on a simple synchronous register port. Software first writes a configuration word while the controller is disabled. The word picks the character length, the bit order, the serial clock divisor and an internal loopback. Software then sets the enable bit and writes characters to the transmit register. Each character is shifted out on MOSI in SPI mode 0 while MISO is sampled. The received character then appears right-justified in the receive register.

Two sticky event flags report progress. Receive-ready is set when a received character lands in the receive register. Transmit-space is set when the shifter takes the held character, so the holding register is free again. Both flags stay set until software writes a one to them. A two-bit mask routes the flags onto one level interrupt. A transmit holding register in front of the shifter lets software queue one character while another is being shifted. Chip selects are driven elsewhere by general-purpose pins.

The register port is word-addressed:

| Index | Register | Read | Write |
|-------|----------|------|-------|
| 0 | configuration | current fields | see R9 |
| 1 | events | bit 9 receive-ready, bit 8 transmit-space | write one to clear |
| 2 | mask | bits 9 and 8 | bits 9 and 8 |
| 3 | transmit | 0 | queues a character |
| 4 | receive | last received character | no effect |

Any other index reads 0.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, index 0 reads 0x00000000, index 1 reads 0x00000100 (transmit-space set, receive-ready clear), index 2 and index 4 read 0, and sclk, mosi and irq are low.
- R2: Configuration bits [23:20] set the character length. Code 0 means 32 bits, codes 1 to 3 mean 4 bits, and a code c from 3 to 15 means c+1 bits. A transfer makes exactly that many SCLK pulses.
- R3: Configuration bit 26 set sends the character most-significant bit first; clear sends it least-significant bit first. The character is taken from the low-order bits of the transmit write, and higher bits are ignored.
- R4: SCLK idles low. Each SCLK half period lasts 2*(d+1) system clocks, where d is configuration bits [19:16] (d=1 gives the system clock divided by 8). MOSI holds the first bit from the moment the shifter loads and changes only when SCLK falls. MISO is sampled when SCLK rises.
- R5: Configuration bit 30 set makes the receiver take its own MOSI bits and ignore MISO.
- R6: At the end of the last SCLK high phase, index 4 receives the character right-justified and receive-ready (event bit 9) is set.
- R7: A write to index 3 is taken only while configuration bit 24 (enable) is set and the holding register is empty; any other write to index 3 is ignored. A taken write clears transmit-space (event bit 8). Transmit-space is set again when the shifter takes the character, so one more character can be queued while one is shifting.
- R8: Event bits are sticky. Writing a one clears a bit, a set by hardware in the same cycle wins, and reads never clear a bit.
- R9: While enable is set, a write to index 0 changes only the enable bit. Bit 30, bit 26, bit 25 and fields [23:20] and [19:16] keep their values. The whole word is written only while enable is clear. Clearing enable stops a running transfer with SCLK and MOSI low and sets no event.
- R10: irq is high exactly when an event bit and its mask bit (index 2, bits 9 and 8) are both set. Other mask bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low synchronous reset |
| regWrEn | input | 1 | register write strobe |
| regAddr | input | 3 | register word index |
| regWrData | input | 32 | register write data |
| regRdData | output | 32 | read data for regAddr, combinational |
| sclk | output | 1 | serial clock, mode 0 |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| irq | output | 1 | masked level interrupt |

## Verification
The assertions assume that MISO is synchronous to the system clock and stable at each edge. They also assume at most one register write per cycle, and that the configuration fields never change on their own. The bench drives MISO, the address and the write strobe only on the falling system-clock edge, away from the sampling edge. It changes configuration fields only after a write that clears enable. It never relies on a length code outside the decoded set.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic finish;
  } spimStrobe_t;

  function automatic logic [5:0] charBits(input logic [3:0] lenCode);
    if (lenCode == 4'd0)      return 6'd32;
    else if (lenCode < 4'd3)  return 6'd4;
    else                      return {2'b00, lenCode} + 6'd1;
  endfunction

endpackage

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 4,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txBuf,
  output logic              modeLoop,
  output logic              modeMsb,
  output logic [5:0]        charLen,
  output logic              busy,
  output logic              sclk,
  output logic              irq,
  output spimStrobe_t       strobe
);

  localparam int CNT_W   = DIV_W + 1;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int DIV_LSB = 16;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(4);

  logic             modeMaster, modeEn;
  logic [3:0]       lenField;
  logic [DIV_W-1:0] divField;
  logic [1:0]       maskQ;
  logic             rxNe, txNf, bufFull, sclkQ;
  logic [CNT_W-1:0] phaseCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] halfLast;
  logic [IDX_W-1:0] lastIdx;
  logic             phaseEnd, wrMode, wrEvt, wrMask, txAccept;

  assign charLen  = charBits(lenField);
  assign lastIdx  = IDX_W'(charLen - 6'd1);
  assign halfLast = {divField, 1'b1};
  assign phaseEnd = (phaseCnt == halfLast);
  assign wrMode   = regWrEn && (regAddr == A_MODE);
  assign wrEvt    = regWrEn && (regAddr == A_EVT);
  assign wrMask   = regWrEn && (regAddr == A_MASK);
  assign txAccept = regWrEn && (regAddr == A_TX) && modeEn && !bufFull;

  assign strobe.load   = modeEn && !busy && bufFull;
  assign strobe.rise   = modeEn && busy && phaseEnd && !sclkQ;
  assign strobe.fall   = modeEn && busy && phaseEnd && sclkQ && (bitIdx != lastIdx);
  assign strobe.finish = modeEn && busy && phaseEnd && sclkQ && (bitIdx == lastIdx);

  assign sclk = sclkQ;
  assign irq  = |({rxNe, txNf} & maskQ);

  // shift engine
  always_ff @(posedge clk) begin
    if (!rstN || !modeEn) begin
      busy     <= 1'b0;
      sclkQ    <= 1'b0;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (strobe.load) begin
      busy     <= 1'b1;
      sclkQ    <= 1'b0;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (busy) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        sclkQ    <= ~sclkQ;
        if (strobe.fall)   bitIdx <= bitIdx + IDX_W'(1);
        if (strobe.finish) busy   <= 1'b0;
      end else begin
        phaseCnt <= phaseCnt + CNT_W'(1);
      end
    end
  end

  // configuration, mask and transmit holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeLoop   <= 1'b0;
      modeMsb    <= 1'b0;
      modeMaster <= 1'b0;
      modeEn     <= 1'b0;
      lenField   <= '0;
      divField   <= '0;
      maskQ      <= '0;
      txBuf      <= '0;
      bufFull    <= 1'b0;
    end else begin
      if (wrMode) begin
        modeEn <= regWrData[24];
        if (!modeEn) begin
          modeLoop   <= regWrData[30];
          modeMsb    <= regWrData[26];
          modeMaster <= regWrData[25];
          lenField   <= regWrData[23:20];
          divField   <= regWrData[DIV_LSB +: DIV_W];
        end
      end
      if (wrMask) maskQ <= regWrData[9:8];
      if (txAccept) txBuf <= regWrData;
      if (!modeEn || strobe.load) bufFull <= 1'b0;
      else if (txAccept)          bufFull <= 1'b1;
    end
  end

  // sticky events, hardware set wins over write-one clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxNe <= 1'b0;
      txNf <= 1'b1;
    end else begin
      if (strobe.finish)                 rxNe <= 1'b1;
      else if (wrEvt && regWrData[9])    rxNe <= 1'b0;
      if (strobe.load)                   txNf <= 1'b1;
      else if (txAccept || (wrEvt && regWrData[8])) txNf <= 1'b0;
    end
  end

  always_comb begin
    logic [DATA_W-1:0] modeWord;
    modeWord = '0;
    modeWord[30] = modeLoop;
    modeWord[26] = modeMsb;
    modeWord[25] = modeMaster;
    modeWord[24] = modeEn;
    modeWord[23:20] = lenField;
    modeWord[DIV_LSB +: DIV_W] = divField;
    regRdData = '0;
    case (regAddr)
      A_MODE:  regRdData = modeWord;
      A_EVT:   regRdData[9:8] = {rxNe, txNf};
      A_MASK:  regRdData[9:8] = maskQ;
      A_RX:    regRdData = rxData;
      default: regRdData = '0;
    endcase
  end

  assert_ne_after_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxNe) |-> $past(sclkQ));

  assert_fields_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(modeEn) |-> $stable({lenField, divField, modeMsb, modeLoop, modeMaster}));

  assert_off_stops_R9: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |=> (!sclkQ && !busy));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == 2'b00) |-> !irq);

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitIdx <= lastIdx));

endmodule

// File: rtl/spim_datapath.sv
`timescale 1ns/1ps
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strobe,
  input  logic              busy,
  input  logic              modeMsb,
  input  logic              modeLoop,
  input  logic [5:0]        charLen,
  input  logic [DATA_W-1:0] txBuf,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txShift, rxShift;
  logic              bitNow, inBit;
  int                padBits;

  assign padBits = DATA_W - int'(charLen);
  assign bitNow  = modeMsb ? txShift[DATA_W-1] : txShift[0];
  assign mosi    = busy && bitNow;
  assign inBit   = modeLoop ? bitNow : miso;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= modeMsb ? (txBuf << padBits) : txBuf;
        rxShift <= '0;
      end
      if (strobe.rise)
        rxShift <= modeMsb ? {rxShift[DATA_W-2:0], inBit} : {inBit, rxShift[DATA_W-1:1]};
      if (strobe.fall)
        txShift <= modeMsb ? (txShift << 1) : (txShift >> 1);
      if (strobe.finish)
        rxData <= modeMsb ? rxShift : (rxShift >> padBits);
    end
  end

  logic loadS, fallS;
  assign loadS = strobe.load;
  assign fallS = strobe.fall;

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(fallS) && !$past(loadS)) |-> $stable(mosi));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.rise, strobe.fall, strobe.finish}));

endmodule

// File: rtl/spi_master_regs.sv
`timescale 1ns/1ps
module spi_master_regs
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);

  spimStrobe_t       strobe;
  logic [DATA_W-1:0] rxData, txBuf;
  logic              modeLoop, modeMsb, busy;
  logic [5:0]        charLen;

  spim_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxData(rxData),
    .txBuf(txBuf), .modeLoop(modeLoop), .modeMsb(modeMsb), .charLen(charLen),
    .busy(busy), .sclk(sclk), .irq(irq), .strobe(strobe)
  );

  spim_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .modeMsb(modeMsb),
    .modeLoop(modeLoop), .charLen(charLen), .txBuf(txBuf), .miso(miso),
    .mosi(mosi), .rxData(rxData)
  );

endmodule

// File: tb/tb_spi_master_regs.sv
`timescale 1ns/1ps
module tb_spi_master_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd1;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sclk, mosi, irq;
  logic        miso = 1'b0;

  int checks = 0;
  int failures = 0;
  int rises = 0;
  int highCycles = 0;
  logic [31:0] mosiSeq = '0;
  logic        misoForce = 1'b0;
  logic        misoVal = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  spi_master_regs dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .irq(irq)
  );

  // behavioural reference model
  logic        mEn, mLoop, mMsb, mMaster, mNe, mNf, mFull, mBusy, mSclk;
  logic [3:0]  mLen, mDiv;
  logic [1:0]  mMask;
  logic [31:0] mBuf, mChar, mRxv, mRxData;
  int          mCnt, mBit;

  function automatic int lenOf(input logic [3:0] c);
    if (c == 0) return 32;
    if (c < 3) return 4;
    return int'(c) + 1;
  endfunction

  function automatic logic mCurBit();
    int n;
    n = lenOf(mLen);
    return mMsb ? mChar[n-1-mBit] : mChar[mBit];
  endfunction

  function automatic logic [31:0] mRead(input logic [2:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      3'd0: begin v[30] = mLoop; v[26] = mMsb; v[25] = mMaster; v[24] = mEn;
                  v[23:20] = mLen; v[19:16] = mDiv; end
      3'd1: v[9:8] = {mNe, mNf};
      3'd2: v[9:8] = mMask;
      3'd4: v = mRxData;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mLoop = 0; mMsb = 0; mMaster = 0; mNe = 0; mNf = 1; mFull = 0;
      mBusy = 0; mSclk = 0; mLen = 0; mDiv = 0; mMask = 0; mBuf = 0; mChar = 0;
      mRxv = 0; mRxData = 0; mCnt = 0; mBit = 0;
    end else begin
      logic oEn, oFull, sIn, setNe, setNf;
      int n;
      oEn = mEn; oFull = mFull; setNe = 0; setNf = 0;
      n = lenOf(mLen);
      sIn = mLoop ? mCurBit() : miso;
      if (!oEn) begin
        mBusy = 0; mSclk = 0; mCnt = 0; mBit = 0; mFull = 0;
      end else if (mBusy) begin
        if (mCnt == 2*(int'(mDiv)+1) - 1) begin
          mCnt = 0;
          if (!mSclk) begin
            mSclk = 1; mRxv[mBit] = sIn;
          end else begin
            mSclk = 0;
            if (mBit == n-1) begin
              mBusy = 0; setNe = 1; mRxData = 0;
              for (int k = 0; k < n; k++)
                if (mMsb) mRxData[n-1-k] = mRxv[k]; else mRxData[k] = mRxv[k];
            end else mBit++;
          end
        end else mCnt++;
      end else if (oFull) begin
        mBusy = 1; mCnt = 0; mSclk = 0; mBit = 0; mChar = mBuf; mFull = 0; setNf = 1;
      end
      if (regWrEn) begin
        case (regAddr)
          3'd0: if (oEn) mEn = regWrData[24];
                else begin
                  mEn = regWrData[24]; mLoop = regWrData[30]; mMsb = regWrData[26];
                  mMaster = regWrData[25]; mLen = regWrData[23:20]; mDiv = regWrData[19:16];
                end
          3'd1: begin if (regWrData[9]) mNe = 0; if (regWrData[8]) mNf = 0; end
          3'd2: mMask = regWrData[9:8];
          3'd3: if (oEn && !oFull) begin mBuf = regWrData; mFull = 1; mNf = 0; end
          default: ;
        endcase
      end
      if (setNe) mNe = 1;
      if (setNf) mNf = 1;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      logic expMosi, expIrq;
      string tag;
      expMosi = mBusy ? mCurBit() : 1'b0;
      expIrq  = |({mNe, mNf} & mMask);
      if (sclk) highCycles++;
      checks++;
      if (sclk !== mSclk) begin failures++;
        $display("FAIL R4 sclk act=%0b exp=%0b t=%0t", sclk, mSclk, $time); end
      checks++;
      if (mosi !== expMosi) begin failures++;
        $display("FAIL R3 mosi act=%0b exp=%0b t=%0t", mosi, expMosi, $time); end
      checks++;
      if (irq !== expIrq) begin failures++;
        $display("FAIL R10 irq act=%0b exp=%0b t=%0t", irq, expIrq, $time); end
      case (regAddr)
        3'd0: tag = "R9"; 3'd1: tag = "R8"; 3'd2: tag = "R10"; 3'd4: tag = "R6";
        default: tag = "R1";
      endcase
      checks++;
      if (regRdData !== mRead(regAddr)) begin failures++;
        $display("FAIL %s read[%0d] act=%h exp=%h t=%0t", tag, regAddr, regRdData,
                 mRead(regAddr), $time); end
    end
  end

  always @(posedge sclk) begin
    rises++;
    mosiSeq = {mosiSeq[30:0], mosi};
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= misoForce ? misoVal : lfsr[0];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #2;
    v = regRdData;
  endtask

  task automatic waitNe();
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v;
      rd(3'd1, v);
      if (v[9]) break;
    end
  endtask

  function automatic logic [31:0] mw(input logic lp, input logic msb, input logic en,
                                     input logic [3:0] len, input logic [3:0] dv);
    return (32'(lp) << 30) | (32'(msb) << 26) | (32'd1 << 25) | (32'(en) << 24) |
           (32'(len) << 20) | (32'(dv) << 16);
  endfunction

  task automatic setup(input logic lp, input logic msb, input logic [3:0] len,
                       input logic [3:0] dv);
    wr(3'd0, mw(lp, msb, 1'b0, len, dv));
    wr(3'd0, mw(lp, msb, 1'b1, len, dv));
    wr(3'd1, 32'h300);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r0, h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 mode", v, 32'h0);
    rd(3'd1, v); chk("R1 events", v, 32'h100);
    rd(3'd2, v); chk("R1 mask", v, 32'h0);
    rd(3'd4, v); chk("R1 rx", v, 32'h0);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R7 transmit write ignored while disabled
    r0 = rises;
    wr(3'd3, 32'h55);
    repeat (20) @(negedge clk);
    chk("R7 no pulses when disabled", rises - r0, 0);
    rd(3'd1, v); chk("R7 events untouched", v, 32'h100);

    // 8-bit MSB-first loopback
    setup(1'b1, 1'b1, 4'd7, 4'd0);
    rd(3'd0, v); chk("R9 config written while disabled", v, mw(1, 1, 1, 7, 0));
    rd(3'd1, v); chk("R8 write-one clears", v, 32'h0);
    r0 = rises;
    wr(3'd3, 32'hFFFFFFA5);
    waitNe();
    rd(3'd4, v); chk("R5 loopback 8b", v, 32'hA5);
    chk("R2 pulses 8", rises - r0, 8);
    chk("R3 msb order", mosiSeq & 32'hFF, 32'hA5);
    rd(3'd1, v); chk("R7 space set after take", v, 32'h300);
    rd(3'd4, v); rd(3'd4, v);
    rd(3'd1, v); chk("R8 reads keep events", v, 32'h300);

    // R9 fields locked while enabled
    wr(3'd0, mw(0, 0, 1, 3, 3));
    rd(3'd0, v); chk("R9 locked", v, mw(1, 1, 1, 7, 0));
    wr(3'd0, mw(1, 1, 0, 7, 0));
    rd(3'd0, v); chk("R9 enable only cleared", v, mw(1, 1, 0, 7, 0));

    // 6-bit LSB-first, divisor 1
    setup(1'b1, 1'b0, 4'd5, 4'd1);
    r0 = rises; h0 = highCycles;
    wr(3'd3, 32'hFFFFFFCB);
    waitNe();
    rd(3'd4, v); chk("R6 right-justified lsb", v, 32'h0B);
    chk("R3 lsb order", mosiSeq & 32'h3F, 32'h34);
    chk("R2 pulses 6", rises - r0, 6);
    chk("R4 high time div1", highCycles - h0, 24);

    // 32-bit code 0
    wr(3'd0, mw(1, 1, 0, 0, 0));
    setup(1'b1, 1'b1, 4'd0, 4'd0);
    r0 = rises;
    wr(3'd3, 32'h89ABCDEF);
    waitNe();
    rd(3'd4, v); chk("R2 32-bit char", v, 32'h89ABCDEF);
    chk("R2 pulses 32", rises - r0, 32);

    // code 1 gives 4 bits
    wr(3'd0, mw(1, 1, 0, 0, 0));
    setup(1'b1, 1'b1, 4'd1, 4'd0);
    r0 = rises;
    wr(3'd3, 32'hF6);
    waitNe();
    rd(3'd4, v); chk("R2 4-bit char", v, 32'h6);
    chk("R2 pulses 4", rises - r0, 4);

    // MISO sampling versus loopback
    misoForce = 1'b1; misoVal = 1'b1;
    wr(3'd0, mw(1, 1, 0, 1, 0));
    setup(1'b0, 1'b1, 4'd7, 4'd0);
    wr(3'd3, 32'h00);
    waitNe();
    rd(3'd4, v); chk("R4 miso sampled", v, 32'hFF);
    wr(3'd0, mw(0, 1, 0, 7, 0));
    setup(1'b1, 1'b1, 4'd7, 4'd0);
    wr(3'd3, 32'h00);
    waitNe();
    rd(3'd4, v); chk("R5 miso ignored", v, 32'h00);
    misoForce = 1'b0;
    wr(3'd0, mw(1, 1, 0, 7, 0));
    setup(1'b0, 1'b0, 4'd9, 4'd2);
    wr(3'd3, 32'h35A);
    waitNe();

    // R7 queueing: second queued, third rejected
    wr(3'd0, mw(0, 0, 0, 9, 2));
    setup(1'b1, 1'b1, 4'd7, 4'd0);
    r0 = rises;
    wr(3'd3, 32'h11);
    wr(3'd3, 32'h22);
    wr(3'd3, 32'h33);
    rd(3'd1, v); chk("R7 space cleared by queued write", v, 32'h0);
    waitNe();
    wr(3'd1, 32'h200);
    waitNe();
    repeat (40) @(negedge clk);
    rd(3'd4, v); chk("R7 queued char received", v, 32'h22);
    chk("R7 third write dropped", rises - r0, 16);

    // R10 interrupt masking
    wr(3'd2, 32'hFFFFFFFF);
    rd(3'd2, v); chk("R10 mask readback", v, 32'h300);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'h300);
    @(negedge clk); #2;
    chk("R10 irq off after clear", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h42);
    waitNe();
    chk("R10 zero mask holds irq low", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'h200);
    @(negedge clk); #2;
    chk("R10 irq from receive-ready", {31'd0, irq}, 32'd1);

    // R9 disable stops a transfer
    wr(3'd0, mw(1, 1, 0, 7, 0));
    setup(1'b1, 1'b1, 4'd0, 4'd3);
    wr(3'd3, 32'hFFFFFFFF);
    repeat (30) @(negedge clk);
    wr(3'd0, mw(1, 1, 0, 0, 3));
    repeat (3) @(negedge clk);
    #2;
    chk("R9 sclk low after disable", {31'd0, sclk}, 32'd0);
    chk("R9 mosi low after disable", {31'd0, mosi}, 32'd0);
    repeat (200) @(negedge clk);
    rd(3'd1, v); chk("R9 no receive event", v, 32'h100);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule